// File: doc/BRIEF.md
# Switchable Program and Pattern Bank Mapper

This block turns the bank numbers that software writes into a cartridge's registers into ROM page numbers for both address spaces. The CPU side sees four 8 KB program slots. Two of these slots come from writable bank registers, and the other two are fixed at the last two pages of program ROM. The video side sees eight 1 KB pattern slots. These are filled from two 2 KB banks and four 1 KB banks. When the cartridge has no pattern ROM, the eight slots point into an 8 KB pattern RAM instead.

Software uses a three-way write port. A command write latches a target bank index and the two layout mode bits. A data write loads the bank at the latched index. A mirroring write sets the nametable arrangement, unless four-screen wiring is strapped on. Every bank number is reduced modulo the actual ROM size, which is supplied on input pins. All page outputs are combinational from the registers and the size inputs, so a write shows on the outputs in the cycle after its clock edge.

Top module: `bank_mapper`

## Requirements
- R1: After reset, all eight bank registers are 0, both mode bits are clear and `mirror_o` is 0.
- R2: A write with `wr_sel_i`=0 (command) latches the target index from data bits [2:0], the program-swap bit from bit 6 and the pattern-swap bit from bit 7. A write with `wr_sel_i`=1 loads the bank at the latched index. Indices 0–1 are the 2 KB pattern banks, 2–5 are the 1 KB pattern banks, and 6–7 are the program banks. The new mapping appears on the outputs in the next cycle.
- R3: With the program-swap bit clear, the program slots 0..3 read bank6, bank7, second-to-last page, last page.
- R4: With the program-swap bit set, the program slots 0..3 read second-to-last page, bank7, bank6, last page.
- R5: Program bank numbers are reduced modulo 2×`prg_size_i`, the number of 8 KB pages (`prg_size_i` is nonzero and counts 16 KB units).
- R6: Pattern bank numbers are reduced modulo 8×`chr_size_i`, the number of 1 KB pages (`chr_size_i` counts 8 KB units).
- R7: A 2 KB bank holding N fills two consecutive slots with N and N+1, each reduced modulo the page count.
- R8: With the pattern-swap bit clear, bank0 fills slots 0–1, bank1 fills slots 2–3, and banks 2..5 fill slots 4..7. With the bit set, the two halves trade places.
- R9: With `chr_size_i`=0, `chr_ram_o` is 1 and the slots give 1 KB RAM page numbers. With the pattern-swap bit clear, slots 0..7 read 4,5,6,7,0,1,2,3. With it set, they read 0..7.
- R10: With `chr_size_i`=0, data writes to indices 0–5 are ignored, while writes to indices 6–7 still load.
- R11: A mirroring write (`wr_sel_i`=2) sets `mirror_o` to data bit 0. The write is ignored while `four_screen_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 command, 1 bank data, 2 mirroring, 3 none |
| wr_data_i | input | DATA_W | Write data |
| prg_size_i | input | SIZE_W | Program ROM size in 16 KB units |
| chr_size_i | input | SIZE_W | Pattern ROM size in 8 KB units, 0 = RAM |
| four_screen_i | input | 1 | Four-screen strap, blocks mirroring writes |
| prg_page_o | output | 4×(SIZE_W+1) | 8 KB page for each CPU slot |
| chr_page_o | output | 8×(SIZE_W+3) | 1 KB page for each video slot |
| chr_ram_o | output | 1 | Slots address pattern RAM |
| mirror_o | output | 1 | Nametable arrangement select |

## Verification
The bench builds the block with SIZE_W=3 and DATA_W=8. With these values, 8-bit bank numbers run well past page counts such as 6, 10 or 56, so the modulo paths are exercised with divisors that are not powers of two. This includes the N+1 carry from 255 into a ninth bit. The size inputs are changed at run time, so a write dropped while no pattern ROM is present can be exposed by switching a ROM size back on.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_BANK   = 2'd1,
    SEL_MIRROR = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  localparam int NUM_BANKS     = 8;
  localparam int IDX_W         = $clog2(NUM_BANKS);
  localparam int NUM_CHR_BANKS = 6;
  localparam int FIRST_PRG_IDX = 6;
  localparam int PRG_SWAP_BIT  = 6;
  localparam int CHR_SWAP_BIT  = 7;
  localparam int NUM_PRG_SLOTS = 4;
  localparam int NUM_CHR_SLOTS = 8;
endpackage

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
  import bank_mapper_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [1:0]                       wr_sel_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             chr_rom_i,
  input  logic                             four_screen_i,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] banks_o,
  output logic                             prg_swap_o,
  output logic                             chr_swap_o,
  output logic                             mirror_o
);
  logic [IDX_W-1:0] idx_q;
  logic             bank_we;

  // pattern banks are frozen when the slots point at RAM
  assign bank_we = chr_rom_i || (int'(idx_q) >= FIRST_PRG_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      banks_o    <= '0;
      idx_q      <= '0;
      prg_swap_o <= 1'b0;
      chr_swap_o <= 1'b0;
      mirror_o   <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_sel_e'(wr_sel_i))
        SEL_CMD: begin
          idx_q      <= wr_data_i[IDX_W-1:0];
          prg_swap_o <= wr_data_i[PRG_SWAP_BIT];
          chr_swap_o <= wr_data_i[CHR_SWAP_BIT];
        end
        SEL_BANK: begin
          if (bank_we) banks_o[idx_q] <= wr_data_i;
        end
        SEL_MIRROR: begin
          if (!four_screen_i) mirror_o <= wr_data_i[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bank_mapper_prg.sv
module bank_mapper_prg
  import bank_mapper_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int DATA_W = 8,
  localparam int PW = SIZE_W + 1,
  localparam int MW = (DATA_W > PW) ? DATA_W : PW
) (
  input  logic [SIZE_W-1:0]                 prg_size_i,
  input  logic [DATA_W-1:0]                 bank_a_i,
  input  logic [DATA_W-1:0]                 bank_b_i,
  input  logic                              swap_i,
  output logic [NUM_PRG_SLOTS-1:0][PW-1:0]  page_o
);
  logic [MW-1:0] n_pages, red_a, red_b, last_pg, prev_pg;

  always_comb begin
    n_pages = MW'({prg_size_i, 1'b0});
    red_a   = '0;
    red_b   = '0;
    last_pg = '0;
    prev_pg = '0;
    if (n_pages != '0) begin
      red_a   = MW'(bank_a_i) % n_pages;
      red_b   = MW'(bank_b_i) % n_pages;
      last_pg = n_pages - MW'(1);
      prev_pg = n_pages - MW'(2);
    end
  end

  always_comb begin
    page_o[0] = swap_i ? prev_pg[PW-1:0] : red_a[PW-1:0];
    page_o[1] = red_b[PW-1:0];
    page_o[2] = swap_i ? red_a[PW-1:0] : prev_pg[PW-1:0];
    page_o[3] = last_pg[PW-1:0];
  end
endmodule

// File: rtl/bank_mapper_chr.sv
module bank_mapper_chr
  import bank_mapper_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int DATA_W = 8,
  localparam int CW = SIZE_W + 3,
  localparam int MW = ((DATA_W + 1) > CW) ? (DATA_W + 1) : CW
) (
  input  logic [SIZE_W-1:0]                     chr_size_i,
  input  logic [NUM_CHR_BANKS-1:0][DATA_W-1:0]  banks_i,
  input  logic                                  swap_i,
  output logic [NUM_CHR_SLOTS-1:0][CW-1:0]      page_o,
  output logic                                  ram_o
);
  localparam int HALF = NUM_CHR_SLOTS / 2;

  logic [MW-1:0] n_pages;
  logic [MW-1:0] red_q [NUM_CHR_SLOTS];

  assign n_pages = MW'({chr_size_i, 3'b000});
  assign ram_o   = (chr_size_i == '0);

  // unswapped layout: 2 KB pairs in the lower half, 1 KB banks in the upper
  for (genvar g = 0; g < NUM_CHR_SLOTS; g++) begin : g_slot
    logic [MW-1:0] raw;
    if (g < HALF) begin : g_pair
      assign raw = MW'(banks_i[g/2]) + MW'(g % 2);
    end else begin : g_single
      assign raw = MW'(banks_i[g-2]);
    end
    assign red_q[g] = (n_pages == '0) ? '0 : raw % n_pages;
  end

  always_comb begin
    for (int k = 0; k < NUM_CHR_SLOTS; k++) begin
      if (ram_o) begin
        page_o[k] = CW'(swap_i ? k : (k ^ HALF));
      end else begin
        page_o[k] = red_q[swap_i ? (k ^ HALF) : k][CW-1:0];
      end
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int DATA_W = 8,
  localparam int PRG_PAGE_W = SIZE_W + 1,
  localparam int CHR_PAGE_W = SIZE_W + 3
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     wr_en_i,
  input  logic [1:0]                               wr_sel_i,
  input  logic [DATA_W-1:0]                        wr_data_i,
  input  logic [SIZE_W-1:0]                        prg_size_i,
  input  logic [SIZE_W-1:0]                        chr_size_i,
  input  logic                                     four_screen_i,
  output logic [NUM_PRG_SLOTS-1:0][PRG_PAGE_W-1:0] prg_page_o,
  output logic [NUM_CHR_SLOTS-1:0][CHR_PAGE_W-1:0] chr_page_o,
  output logic                                     chr_ram_o,
  output logic                                     mirror_o
);
  logic [NUM_BANKS-1:0][DATA_W-1:0] banks;
  logic                             prg_swap, chr_swap;
  logic                             chr_rom;

  assign chr_rom = (chr_size_i != '0);

  bank_mapper_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .chr_rom_i     (chr_rom),
    .four_screen_i (four_screen_i),
    .banks_o       (banks),
    .prg_swap_o    (prg_swap),
    .chr_swap_o    (chr_swap),
    .mirror_o      (mirror_o)
  );

  bank_mapper_prg #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) i_prg (
    .prg_size_i (prg_size_i),
    .bank_a_i   (banks[FIRST_PRG_IDX]),
    .bank_b_i   (banks[FIRST_PRG_IDX+1]),
    .swap_i     (prg_swap),
    .page_o     (prg_page_o)
  );

  bank_mapper_chr #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) i_chr (
    .chr_size_i (chr_size_i),
    .banks_i    (banks[NUM_CHR_BANKS-1:0]),
    .swap_i     (chr_swap),
    .page_o     (chr_page_o),
    .ram_o      (chr_ram_o)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
  import bank_mapper_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int DATA_W = 8,
  localparam int PW = SIZE_W + 1,
  localparam int CW = SIZE_W + 3
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [1:0]                       wr_sel_i,
  input logic [DATA_W-1:0]                wr_data_i,
  input logic [SIZE_W-1:0]                prg_size_i,
  input logic [SIZE_W-1:0]                chr_size_i,
  input logic                             four_screen_i,
  input logic [NUM_PRG_SLOTS-1:0][PW-1:0] prg_page_o,
  input logic [NUM_CHR_SLOTS-1:0][CW-1:0] chr_page_o,
  input logic                             chr_ram_o,
  input logic                             mirror_o
);
  int n_prg, n_chr;
  assign n_prg = 2 * int'(prg_size_i);
  assign n_chr = 8 * int'(chr_size_i);

  AST_LAST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_prg != 0) |-> (int'(prg_page_o[3]) == n_prg - 1)); // R3

  AST_PRG_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_prg != 0) |-> (int'(prg_page_o[0]) < n_prg && int'(prg_page_o[1]) < n_prg &&
                      int'(prg_page_o[2]) < n_prg)); // R5

  AST_CMD_KEEPS_SLOT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> (!$stable(prg_size_i) || $stable(prg_page_o[1]))); // R4

  AST_PAIR_ADJACENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_chr != 0) |->
      ((int'(chr_page_o[1]) == (int'(chr_page_o[0]) + 1) % n_chr &&
        int'(chr_page_o[3]) == (int'(chr_page_o[2]) + 1) % n_chr) ||
       (int'(chr_page_o[5]) == (int'(chr_page_o[4]) + 1) % n_chr &&
        int'(chr_page_o[7]) == (int'(chr_page_o[6]) + 1) % n_chr))); // R7

  AST_RAM_HALVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_size_i == '0) |-> (chr_ram_o &&
      ((chr_page_o[0] == CW'(0) && chr_page_o[4] == CW'(4)) ||
       (chr_page_o[0] == CW'(4) && chr_page_o[4] == CW'(0))))); // R9

  AST_MIRROR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2 && four_screen_i) |=> $stable(mirror_o)); // R11

  AST_MIRROR_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2 && !four_screen_i) |=> (mirror_o == $past(wr_data_i[0]))); // R11
endmodule

bind bank_mapper bank_mapper_chk #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_sel_i      (wr_sel_i),
  .wr_data_i     (wr_data_i),
  .prg_size_i    (prg_size_i),
  .chr_size_i    (chr_size_i),
  .four_screen_i (four_screen_i),
  .prg_page_o    (prg_page_o),
  .chr_page_o    (chr_page_o),
  .chr_ram_o     (chr_ram_o),
  .mirror_o      (mirror_o)
);

// File: tb/test_bank_mapper.sv
module test_bank_mapper;
  localparam int SIZE_W = 3;
  localparam int DATA_W = 8;
  localparam int PW = SIZE_W + 1;
  localparam int CW = SIZE_W + 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = 2'd3;
  logic [DATA_W-1:0] wr_data = '0;
  logic [SIZE_W-1:0] prg_size = 3'd3;
  logic [SIZE_W-1:0] chr_size = 3'd2;
  logic              four_screen = 1'b0;
  logic [3:0][PW-1:0] prg_page;
  logic [7:0][CW-1:0] chr_page;
  logic              chr_ram, mirror;

  bank_mapper #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) i_bank_mapper (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .prg_size_i(prg_size), .chr_size_i(chr_size),
    .four_screen_i(four_screen), .prg_page_o(prg_page), .chr_page_o(chr_page),
    .chr_ram_o(chr_ram), .mirror_o(mirror)
  );

  always #10 clk = ~clk; // 50 MHz

  int    vectors = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int m_bank[8];
  int m_idx;
  bit m_ps, m_cs, m_mir;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_bank[i]) m_bank[i] = 0;
      m_idx = 0; m_ps = 0; m_cs = 0; m_mir = 0;
    end else if (wr_en) begin
      if (wr_sel == 2'd0) begin
        m_idx = int'(wr_data) % 8;
        m_ps  = wr_data[6];
        m_cs  = wr_data[7];
      end else if (wr_sel == 2'd1) begin
        if (chr_size != 0 || m_idx >= 6) m_bank[m_idx] = int'(wr_data);
      end else if (wr_sel == 2'd2) begin
        if (!four_screen) m_mir = wr_data[0];
      end
    end
  end

  function automatic int exp_prg(int slot);
    int n, b6, b7;
    n = 2 * int'(prg_size);
    if (n == 0) return 0;
    b6 = m_bank[6] % n;
    b7 = m_bank[7] % n;
    case (slot)
      0: return m_ps ? n - 2 : b6;
      1: return b7;
      2: return m_ps ? b6 : n - 2;
      default: return n - 1;
    endcase
  endfunction

  function automatic int exp_chr(int slot);
    int n, pos, v;
    n = 8 * int'(chr_size);
    if (n == 0) return m_cs ? slot : (slot + 4) % 8;
    pos = m_cs ? (slot + 4) % 8 : slot;
    if (pos < 4) v = m_bank[pos / 2] + pos % 2;
    else         v = m_bank[pos - 2];
    return v % n;
  endfunction

  task automatic cmp(string what, int got, int exp);
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      for (int k = 0; k < 4; k++) cmp($sformatf("prg slot %0d", k), int'(prg_page[k]), exp_prg(k));
      for (int k = 0; k < 8; k++) cmp($sformatf("chr slot %0d", k), int'(chr_page[k]), exp_chr(k));
      cmp("chr_ram", int'(chr_ram), (chr_size == 0) ? 1 : 0);
      cmp("mirror", int'(mirror), int'(m_mir));
    end
  end

  task automatic wr(input logic [1:0] s, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = DATA_W'(d);
    @(posedge clk); #1;
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    // R2 R6 R7: load every bank through index then data
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, i);
      wr(2'd1, i * 37 + 5);
    end
    idle(2);
    cur_req = "R4"; wr(2'd0, 8'h40); idle(2);
    cur_req = "R8"; wr(2'd0, 8'h80); idle(2);
    wr(2'd0, 8'hC0); idle(2);
    cur_req = "R3"; wr(2'd0, 8'h00); idle(2);

    // R5 R6: other sizes, wrap of large bank numbers
    cur_req = "R5";
    prg_size = 3'd5; chr_size = 3'd7; idle(2);
    wr(2'd0, 6); wr(2'd1, 255);
    wr(2'd0, 7); wr(2'd1, 200);
    wr(2'd0, 8'h46); idle(2);
    cur_req = "R6";
    wr(2'd0, 1); wr(2'd1, 255);
    wr(2'd0, 5); wr(2'd1, 250);
    cur_req = "R7"; wr(2'd0, 8'h80); idle(2);
    wr(2'd0, 0); wr(2'd1, 55); idle(2);

    // R11 mirroring with and without the strap
    cur_req = "R11";
    wr(2'd2, 1); wr(2'd2, 0); wr(2'd2, 3);
    four_screen = 1'b1; wr(2'd2, 0); wr(2'd2, 2);
    four_screen = 1'b0; wr(2'd2, 0); idle(2);

    // R9 R10: no pattern ROM
    cur_req = "R9";
    chr_size = 3'd0; wr(2'd0, 0); idle(2);
    wr(2'd0, 8'h80); idle(2);
    cur_req = "R10";
    wr(2'd0, 8'h02); wr(2'd1, 9);
    wr(2'd0, 8'h00); wr(2'd1, 77);
    wr(2'd0, 8'h06); wr(2'd1, 33);
    chr_size = 3'd4; idle(3);

    // mixed traffic
    cur_req = "R2";
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 50 == 0) begin
        prg_size = SIZE_W'((lfsr[10:8] % 7) + 1);
        chr_size = SIZE_W'(lfsr[13:11]);
        four_screen = lfsr[14];
      end
      wr(2'(lfsr[1:0] % 3), int'(lfsr[15:8]));
    end
    idle(3);
    finish_run();
  end
endmodule